// File: doc/BRIEF.md
# Register-Port to 64-bit Command Bridge

This block lets a host that can only move 32 bits at a time issue 64-bit read and write transactions to a downstream register target. The host sees four 32-bit registers behind a two-bit select. Two of them stage the upper and lower halves of the 64-bit data word. One is the command register, and one is the status register. A write to the command register carries the direction and a 31-bit target address in a single word. That write alone starts the downstream transaction.

The downstream side is a request channel with valid/ready flow control and a response channel that is always accepted. A response carries 64 bits of data, a 3-bit error code and an abort flag. The bridge stays busy from the command write until the response arrives. During that time it refuses further command and data writes and records the attempt. After a successful read, both data halves are refreshed together. After a failure, the status register shows the cause and the data registers keep their old contents.

Top module: `cmdbr_top`

## Requirements
- R1: After reset all four host registers read zero and no request is presented. The register select codes are: 0 is the upper data half (bits 63:32), 1 is the lower data half (bits 31:0), 2 is command and 3 is status.
- R2: A command write while idle presents a request on the next cycle. Command bit 31 gives the direction (1 is a write, 0 is a read) and command bits 30:0 give the request address.
- R3: A write request carries the upper data register as bits 63:32 and the lower data register as bits 31:0 of its payload.
- R4: The request stays valid with unchanged fields until it is accepted. Status bit 0 (busy) is set from the command write until the response is taken.
- R5: A response to a read with error code 0 and no abort loads both data registers in the same clock and clears busy. A write response leaves the data registers unchanged.
- R6: A response stores its error code in status bits 14:12 and its abort flag in status bit 4. A read that fails (nonzero code or abort) leaves both data registers unchanged.
- R7: A write to the command or to either data register while busy is ignored and sets status bit 1 (illegal access).
- R8: A write of any value to the status register clears the error field, the abort bit and the illegal-access bit. If a response arrives in that same cycle, the response's error code and abort flag are kept.
- R9: Launching a new transaction clears the previous error and abort. A response that arrives while no request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regSel | input | 2 | Host register select |
| regWrData | input | 32 | Host write data |
| regRdData | output | 32 | Selected register contents |
| reqValid | output | 1 | Downstream request valid |
| reqReady | input | 1 | Downstream request accepted |
| reqWrite | output | 1 | Request direction, 1 is write |
| reqAddr | output | 31 | Request address |
| reqData | output | 64 | Write payload |
| rspValid | input | 1 | Response valid |
| rspData | input | 64 | Read data from the response |
| rspErr | input | 3 | Response error code, 0 is success |
| rspAbort | input | 1 | Response abort flag |

## Verification
Two events can meet in one clock: the host writing the status register to clear it, and a response capturing a new error code. The bench drives both in the same cycle and expects the status register to show the response's code afterwards rather than zero. A second overlap is a host command write in a cycle where the bridge is still busy. The bench checks that this write raises the illegal-access bit and leaves the outstanding request's address and data untouched.

// File: rtl/cmdbr_pkg.sv
package cmdbr_pkg;
  typedef enum logic [1:0] {
    SEL_HI   = 2'd0,
    SEL_LO   = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_STAT = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;   // latch command, clear old result
    logic ldHi;     // host write to upper data half
    logic ldLo;     // host write to lower data half
    logic capRsp;   // capture error code and abort
    logic ldRead;   // load read data into both halves
    logic clrStat;  // host write to status
  } strobe_t;
endpackage

// File: rtl/cmdbr_ctrl.sv
module cmdbr_ctrl
  import cmdbr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  input  logic       cmdWrite,
  input  logic       reqReady,
  input  logic       rspValid,
  input  logic       rspFail,
  output strobe_t    strb,
  output logic       busy,
  output logic       illegal,
  output logic       reqValid
);
  state_e  state;
  regSel_e sel;
  logic    idle, rspTake, busyWrite;

  assign sel       = regSel_e'(regSel);
  assign idle      = (state == ST_IDLE);
  assign busy      = !idle;
  assign reqValid  = (state == ST_ISSUE);
  assign rspTake   = (state == ST_WAIT) && rspValid;
  assign busyWrite = regWrEn && busy && (sel != SEL_STAT);

  always_comb begin
    strb.launch  = regWrEn && idle && (sel == SEL_CMD);
    strb.ldHi    = regWrEn && idle && (sel == SEL_HI);
    strb.ldLo    = regWrEn && idle && (sel == SEL_LO);
    strb.clrStat = regWrEn && (sel == SEL_STAT);
    strb.capRsp  = rspTake;
    strb.ldRead  = rspTake && !cmdWrite && !rspFail;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (strb.launch) state <= ST_ISSUE;
        ST_ISSUE: if (reqReady)    state <= ST_WAIT;
        ST_WAIT:  if (rspValid)    state <= ST_IDLE;
        default:                   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             illegal <= 1'b0;
    else if (busyWrite)    illegal <= 1'b1;
    else if (strb.clrStat) illegal <= 1'b0;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid); // R4
  AST_ILLEGAL_SET: assert property (@(posedge clk) disable iff (!rstN)
    busyWrite |=> illegal); // R7
  AST_RSP_FREES: assert property (@(posedge clk) disable iff (!rstN)
    rspTake |=> !busy); // R5
  AST_LAUNCH_PRESENTS: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |=> reqValid); // R2
endmodule

// File: rtl/cmdbr_dpath.sv
module cmdbr_dpath
  import cmdbr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ERR_W  = 3,
  localparam int HALF_W = DATA_W / 2,
  localparam int ADDR_W = HALF_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [1:0]        regSel,
  input  logic [HALF_W-1:0] regWrData,
  input  logic [DATA_W-1:0] rspData,
  input  logic [ERR_W-1:0]  rspErr,
  input  logic              rspAbort,
  input  logic              busy,
  input  logic              illegal,
  output logic [HALF_W-1:0] regRdData,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData
);
  localparam int BUSY_BIT  = 0;
  localparam int ILL_BIT   = 1;
  localparam int ABORT_BIT = 4;
  localparam int ERR_LSB   = 12;

  logic [HALF_W-1:0] dataHi, dataLo, cmdReg, statWord;
  logic [ERR_W-1:0]  errReg;
  logic              abortReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataHi <= '0;
      dataLo <= '0;
    end else if (strb.ldRead) begin
      dataHi <= rspData[DATA_W-1:HALF_W];
      dataLo <= rspData[HALF_W-1:0];
    end else begin
      if (strb.ldHi) dataHi <= regWrData;
      if (strb.ldLo) dataLo <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cmdReg <= '0;
    else if (strb.launch) cmdReg <= regWrData;
  end

  // a response outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errReg   <= '0;
      abortReg <= 1'b0;
    end else if (strb.capRsp) begin
      errReg   <= rspErr;
      abortReg <= rspAbort;
    end else if (strb.launch || strb.clrStat) begin
      errReg   <= '0;
      abortReg <= 1'b0;
    end
  end

  always_comb begin
    statWord                       = '0;
    statWord[BUSY_BIT]             = busy;
    statWord[ILL_BIT]              = illegal;
    statWord[ABORT_BIT]            = abortReg;
    statWord[ERR_LSB +: ERR_W]     = errReg;
  end

  always_comb begin
    case (regSel_e'(regSel))
      SEL_HI:  regRdData = dataHi;
      SEL_LO:  regRdData = dataLo;
      SEL_CMD: regRdData = cmdReg;
      default: regRdData = statWord;
    endcase
  end

  assign reqWrite = cmdReg[HALF_W-1];
  assign reqAddr  = cmdReg[ADDR_W-1:0];
  assign reqData  = {dataHi, dataLo};

  AST_READ_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldRead |=> reqData == $past(rspData)); // R5
  AST_RSP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.capRsp |=> errReg == $past(rspErr) && abortReg == $past(rspAbort)); // R8
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cmdReg)); // R7
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strb.ldRead |=> $stable(reqData)); // R6
endmodule

// File: rtl/cmdbr_top.sv
module cmdbr_top
  import cmdbr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ERR_W  = 3,
  localparam int HALF_W = DATA_W / 2,
  localparam int ADDR_W = HALF_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [HALF_W-1:0] regWrData,
  output logic [HALF_W-1:0] regRdData,
  output logic              reqValid,
  input  logic              reqReady,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  input  logic              rspValid,
  input  logic [DATA_W-1:0] rspData,
  input  logic [ERR_W-1:0]  rspErr,
  input  logic              rspAbort
);
  strobe_t strb;
  logic    busy, illegal, rspFail;

  assign rspFail = (rspErr != '0) || rspAbort;

  cmdbr_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .cmdWrite (reqWrite),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspFail  (rspFail),
    .strb     (strb),
    .busy     (busy),
    .illegal  (illegal),
    .reqValid (reqValid)
  );

  cmdbr_dpath #(.DATA_W(DATA_W), .ERR_W(ERR_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regSel    (regSel),
    .regWrData (regWrData),
    .rspData   (rspData),
    .rspErr    (rspErr),
    .rspAbort  (rspAbort),
    .busy      (busy),
    .illegal   (illegal),
    .regRdData (regRdData),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqData   (reqData)
  );
endmodule

// File: tb/cmdbr_top_tb.sv
module cmdbr_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regSel;
  logic [31:0] regWrData, regRdData;
  logic        reqValid, reqReady, reqWrite;
  logic [30:0] reqAddr;
  logic [63:0] reqData, rspData;
  logic        rspValid, rspAbort;
  logic [2:0]  rspErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cmdbr_top dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqReady(reqReady), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqData(reqData), .rspValid(rspValid), .rspData(rspData),
    .rspErr(rspErr), .rspAbort(rspAbort)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(logic [1:0] sel, logic [31:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic hostRead(logic [1:0] sel, output logic [31:0] val);
    regSel = sel;
    #1 val = regRdData;
  endtask

  task automatic handshake();
    reqReady = 1'b1;
    @(negedge clk);
    reqReady = 1'b0;
  endtask

  task automatic respond(logic [63:0] d, logic [2:0] e, logic a);
    rspValid = 1'b1; rspData = d; rspErr = e; rspAbort = a;
    @(negedge clk);
    rspValid = 1'b0; rspErr = '0; rspAbort = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int s = 0; s < 4; s++) begin
      hostRead(s[1:0], v);
      check("R1 reset register", v, 0);
    end
    check("R1 no request after reset", reqValid, 0);
  endtask

  task automatic testWrite();
    logic [31:0] v;
    hostWrite(2'd0, 32'hA5A5_0001);
    hostWrite(2'd1, 32'h5A5A_0002);
    hostWrite(2'd2, 32'h8000_1234);
    check("R2 request valid", reqValid, 1);
    check("R2 direction write", reqWrite, 1);
    check("R2 address", reqAddr, 31'h1234);
    check("R3 payload halves", reqData, 64'hA5A5_0001_5A5A_0002);
    hostRead(2'd3, v);
    check("R4 busy set", v, 32'h1);
    @(negedge clk); @(negedge clk);
    check("R4 request held", reqValid, 1);
    check("R4 address held", reqAddr, 31'h1234);
    handshake();
    check("R4 request dropped after accept", reqValid, 0);
    hostRead(2'd3, v);
    check("R4 busy while waiting", v, 32'h1);
    respond(64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 1'b0);
    hostRead(2'd3, v);
    check("R5 write done status", v, 32'h0);
    hostRead(2'd0, v);
    check("R5 write rsp keeps upper", v, 32'hA5A5_0001);
    hostRead(2'd1, v);
    check("R5 write rsp keeps lower", v, 32'h5A5A_0002);
  endtask

  task automatic testRead();
    logic [31:0] v;
    hostWrite(2'd2, 32'h7FFF_FFFF);
    check("R2 direction read", reqWrite, 0);
    check("R2 max address", reqAddr, 31'h7FFF_FFFF);
    handshake();
    respond(64'h1122_3344_5566_7788, 3'd0, 1'b0);
    hostRead(2'd0, v);
    check("R5 read upper", v, 32'h1122_3344);
    hostRead(2'd1, v);
    check("R5 read lower", v, 32'h5566_7788);
    hostRead(2'd3, v);
    check("R5 busy cleared", v, 32'h0);
  endtask

  task automatic testFail();
    logic [31:0] v;
    hostWrite(2'd2, 32'h0000_0040);
    handshake();
    respond(64'hDEAD_BEEF_DEAD_BEEF, 3'b001, 1'b0);
    hostRead(2'd3, v);
    check("R6 blocked code", v, 32'h1000);
    hostRead(2'd0, v);
    check("R6 failed read keeps upper", v, 32'h1122_3344);
    hostWrite(2'd2, 32'h0000_0041);
    hostRead(2'd3, v);
    check("R9 launch clears old error", v, 32'h1);
    handshake();
    respond(64'hCAFE_CAFE_CAFE_CAFE, 3'd0, 1'b1);
    hostRead(2'd3, v);
    check("R6 abort bit", v, 32'h10);
    hostRead(2'd1, v);
    check("R6 aborted read keeps lower", v, 32'h5566_7788);
    hostWrite(2'd3, 32'h0);
    hostRead(2'd3, v);
    check("R8 status write clears", v, 32'h0);
  endtask

  task automatic testBusy();
    logic [31:0] v;
    hostWrite(2'd2, 32'h0000_0100);
    hostWrite(2'd2, 32'h8000_0200);
    hostWrite(2'd0, 32'h0BAD_0BAD);
    hostRead(2'd3, v);
    check("R7 illegal flag while busy", v, 32'h3);
    check("R7 address unchanged", reqAddr, 31'h100);
    check("R7 direction unchanged", reqWrite, 0);
    hostRead(2'd0, v);
    check("R7 data write ignored", v, 32'h1122_3344);
    handshake();
    respond(64'h0, 3'd0, 1'b1);
    hostRead(2'd3, v);
    check("R7 illegal stays after response", v, 32'h12);
    hostWrite(2'd3, 32'hFFFF_FFFF);
    hostRead(2'd3, v);
    check("R8 clears illegal", v, 32'h0);
  endtask

  task automatic testCollision();
    logic [31:0] v;
    hostWrite(2'd2, 32'h8000_0300);
    handshake();
    @(negedge clk);
    regWrEn = 1'b1; regSel = 2'd3; regWrData = 32'h0;
    rspValid = 1'b1; rspData = '0; rspErr = 3'b101; rspAbort = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; rspValid = 1'b0; rspErr = '0; rspAbort = 1'b0;
    hostRead(2'd3, v);
    check("R8 response wins over clear", v, 32'h5010);
  endtask

  task automatic testStray();
    logic [31:0] v;
    hostWrite(2'd3, 32'h0);
    respond(64'h9999_9999_9999_9999, 3'b111, 1'b1);
    hostRead(2'd3, v);
    check("R9 stray response ignored", v, 32'h0);
    hostRead(2'd0, v);
    check("R9 stray keeps data", v, 32'h1122_3344);
  endtask

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regSel = '0; regWrData = '0;
    reqReady = 1'b0; rspValid = 1'b0; rspData = '0; rspErr = '0; rspAbort = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWrite();
    testRead();
    testFail();
    testBusy();
    testCollision();
    testStray();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule